// File: doc/BRIEF.md
# USB Full-Speed Token Packet Transmitter

This block turns one token request (packet type, device address, endpoint number) into the complete serial waveform of a full-speed USB token packet on a differential pair. It prepends the synchronisation pattern and builds the packet identifier byte, which carries the four type bits and their complement. It computes the 5-bit CRC over address and endpoint, inserts stuff bits where long runs of ones occur, NRZI-encodes the result and closes the packet with the single-ended-zero end marker followed by an idle bit.

The caller presents the fields together with a one-cycle `start` while `busy` is low. One line symbol is produced for every cycle in which `bit_en` is high, so an external divider sets the bit rate. `done` pulses in the cycle the final idle bit appears, and `busy` drops at the same time.

Top module: `usb_tok_tx`

## Requirements
- R1: After reset and whenever no packet is in flight, the line is idle J (`line_dp`=1, `line_dm`=0), and `busy` and `done` are low.
- R2: A `start` pulse sampled while `busy` is low latches the three fields, and `busy` reads high from the next cycle until the cycle `done` pulses.
- R3: The first eight line symbols of every packet are K J K J K J K K: seven 0 bits, then a 1 bit, all before NRZI coding.
- R4: The next unstuffed byte carries the packet type in its low four bits and the bitwise complement of the type in its high four bits, and is sent least significant bit first.
- R5: The address (7 bits) and then the endpoint (4 bits) follow, each least significant bit first. Next comes a 5-bit CRC computed over those 11 bits in send order, with polynomial x^5+x^2+1 and an all-ones seed. The CRC is inverted and sent with its most significant bit first.
- R6: The line is NRZI coded. A 0 bit toggles the line between J (dp=1, dm=0) and K (dp=0, dm=1), a 1 bit holds it, and the first bit of a packet is coded relative to J.
- R7: After six consecutive 1 bits in the pre-coding stream, a 0 bit is inserted. This covers the span from synchronisation through the CRC, including a run that ends on the last CRC bit. No bit is inserted into the end marker.
- R8: After the last data or stuff bit, the line shows SE0 (dp=0, dm=0) for two bit times and then J for one. `done` is high for exactly one cycle, in the cycle that J appears.
- R9: The line changes only in cycles that follow a high `bit_en`. With `bit_en` low it holds its value.
- R10: A `start` that arrives while `busy` is high is ignored. The packet in flight is unchanged and no second packet follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One line symbol per high cycle |
| start | input | 1 | Request to send one token packet |
| pkt_type | input | 4 | Packet type nibble |
| dev_addr | input | 7 | Device address |
| endp_num | input | 4 | Endpoint number |
| busy | output | 1 | Packet in flight |
| done | output | 1 | One-cycle pulse with the final idle bit |
| line_dp | output | 1 | Positive line of the pair |
| line_dm | output | 1 | Negative line of the pair |

## Verification
A wrong NRZI level register flips every later symbol, so the mismatch is visible at the first 0 bit after the error. A wrong stuffing count shifts all later symbols by one bit time and changes the packet length. Either fault shows up within one packet as a symbol mismatch, a length mismatch or a misplaced end marker. A faulty CRC chain corrupts only the last five data symbols and their coding. A sequencer stuck in a busy state shows at once as a missing `done` or a `busy` that stays high.

// File: rtl/usb_tok_pkg.sv
package usb_tok_pkg;
  typedef enum logic [1:0] {
    SYM_DATA = 2'd0,
    SYM_SE0  = 2'd1,
    SYM_IDLE = 2'd2
  } sym_kind_e;
endpackage

// File: rtl/tok_crc5.sv
module tok_crc5 #(
  parameter int          DATA_W = 11,
  parameter int          CRC_W  = 5,
  parameter logic [4:0]  POLY   = 5'b00101,
  parameter logic [4:0]  SEED   = 5'b11111
) (
  input  logic [DATA_W-1:0] din,       // din[0] is shifted in first
  output logic [CRC_W-1:0]  crc_field  // crc_field[0] is sent first
);
  logic [CRC_W-1:0] chain [0:DATA_W];

  assign chain[0] = SEED[CRC_W-1:0];

  for (genvar i = 0; i < DATA_W; i++) begin : g_step
    logic fb;
    assign fb = din[i] ^ chain[i][CRC_W-1];
    assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY[CRC_W-1:0] : '0);
  end

  for (genvar j = 0; j < CRC_W; j++) begin : g_out
    assign crc_field[j] = ~chain[DATA_W][CRC_W-1-j];
  end
endmodule

// File: rtl/tok_frame_seq.sv
module tok_frame_seq
  import usb_tok_pkg::*;
#(
  parameter int FRAME_W   = 32,
  parameter int STUFF_RUN = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sym_valid,
  output sym_kind_e          sym_kind,
  output logic               sym_bit,
  output logic               busy,
  output logic               done
);
  localparam int IDX_W  = $clog2(FRAME_W + 1);
  localparam int ONES_W = $clog2(STUFF_RUN + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_BITS, ST_SE0B, ST_JEND} seq_st_e;

  seq_st_e            st_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [IDX_W-1:0]   sent_q;
  logic [ONES_W-1:0]  ones_q;
  logic               stuff_now, frame_end;

  assign stuff_now = (ones_q == ONES_W'(STUFF_RUN));
  assign frame_end = (sent_q == IDX_W'(FRAME_W));

  always_comb begin
    sym_valid = bit_en && (st_q != ST_IDLE);
    sym_kind  = SYM_DATA;
    sym_bit   = 1'b0;
    case (st_q)
      ST_BITS: begin
        if (stuff_now)      sym_bit  = 1'b0;
        else if (frame_end) sym_kind = SYM_SE0;
        else                sym_bit  = shreg_q[0];
      end
      ST_SE0B: sym_kind = SYM_SE0;
      ST_JEND: sym_kind = SYM_IDLE;
      default: sym_kind = SYM_DATA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      shreg_q <= '0;
      sent_q  <= '0;
      ones_q  <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            shreg_q <= frame_i;
            sent_q  <= '0;
            ones_q  <= '0;
            busy    <= 1'b1;
            st_q    <= ST_BITS;
          end
        end
        ST_BITS: begin
          if (bit_en) begin
            if (stuff_now) begin
              ones_q <= '0;
            end else if (frame_end) begin
              st_q <= ST_SE0B;
            end else begin
              ones_q  <= shreg_q[0] ? ones_q + 1'b1 : '0;
              shreg_q <= shreg_q >> 1;
              sent_q  <= sent_q + 1'b1;
            end
          end
        end
        ST_SE0B: if (bit_en) st_q <= ST_JEND;
        ST_JEND: begin
          if (bit_en) begin
            st_q <= ST_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R7: the run counter never passes the stuffing threshold
  a_r7_run_bounded: assert property (@(posedge clk) disable iff (rst)
    ones_q <= ONES_W'(STUFF_RUN));

  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: busy is low whenever done is reported
  a_r2_busy_clear_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/tok_line_drv.sv
module tok_line_drv
  import usb_tok_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sym_valid,
  input  sym_kind_e sym_kind,
  input  logic      sym_bit,
  output logic      dp_o,
  output logic      dm_o
);
  logic lvl_q;  // 1 = J, 0 = K
  logic lvl_d;

  assign lvl_d = sym_bit ? lvl_q : ~lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b1;
      dp_o  <= 1'b1;
      dm_o  <= 1'b0;
    end else if (sym_valid) begin
      case (sym_kind)
        SYM_DATA: begin
          lvl_q <= lvl_d;
          dp_o  <= lvl_d;
          dm_o  <= ~lvl_d;
        end
        SYM_SE0: begin
          dp_o <= 1'b0;
          dm_o <= 1'b0;
        end
        default: begin
          lvl_q <= 1'b1;
          dp_o  <= 1'b1;
          dm_o  <= 1'b0;
        end
      endcase
    end
  end

  // R6: a coded 0 always flips the differential level
  a_r6_zero_toggles: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_kind == SYM_DATA && !sym_bit) |=> (dp_o != $past(dp_o)));

  // R9: no symbol, no line change
  a_r9_line_hold: assert property (@(posedge clk) disable iff (rst)
    !sym_valid |=> $stable({dp_o, dm_o}));
endmodule

// File: rtl/usb_tok_tx.sv
module usb_tok_tx #(
  parameter int SYNC_W    = 8,
  parameter int TYPE_W    = 4,
  parameter int ADDR_W    = 7,
  parameter int ENDP_W    = 4,
  parameter int CRC_W     = 5,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              start,
  input  logic [TYPE_W-1:0] pkt_type,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [ENDP_W-1:0] endp_num,
  output logic              busy,
  output logic              done,
  output logic              line_dp,
  output logic              line_dm
);
  import usb_tok_pkg::*;

  localparam int CRC_IN_W = ADDR_W + ENDP_W;
  localparam int FRAME_W  = SYNC_W + 2 * TYPE_W + CRC_IN_W + CRC_W;
  localparam logic [SYNC_W-1:0] SYNC_PAT = SYNC_W'(1) << (SYNC_W - 1);

  logic [CRC_W-1:0]   crc_field;
  logic [FRAME_W-1:0] frame;
  logic               sym_valid, sym_bit;
  sym_kind_e          sym_kind;

  tok_crc5 #(.DATA_W(CRC_IN_W), .CRC_W(CRC_W)) u_crc (
    .din       ({endp_num, dev_addr}),
    .crc_field (crc_field)
  );

  // bit 0 of the frame leaves first
  assign frame = {crc_field, endp_num, dev_addr, ~pkt_type, pkt_type, SYNC_PAT};

  tok_frame_seq #(.FRAME_W(FRAME_W), .STUFF_RUN(STUFF_RUN)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .start     (start),
    .frame_i   (frame),
    .sym_valid (sym_valid),
    .sym_kind  (sym_kind),
    .sym_bit   (sym_bit),
    .busy      (busy),
    .done      (done)
  );

  tok_line_drv u_line (
    .clk       (clk),
    .rst       (rst),
    .sym_valid (sym_valid),
    .sym_kind  (sym_kind),
    .sym_bit   (sym_bit),
    .dp_o      (line_dp),
    .dm_o      (line_dm)
  );

  // R1: with nothing in flight the pair rests at J
  a_r1_idle_is_j: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (line_dp && !line_dm));

  // R10: a start during a packet does not end it early
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !bit_en) |=> busy);
endmodule

// File: tb/usb_tok_tx_tb.sv
module usb_tok_tx_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       start = 1'b0;
  logic [3:0] pkt_type = '0;
  logic [6:0] dev_addr = '0;
  logic [3:0] endp_num = '0;
  logic       busy, done, line_dp, line_dm;

  int n_chk = 0;
  int n_bad = 0;

  logic [1:0] exp_line [0:63];
  logic [1:0] got_line [0:63];
  int         exp_n;

  always #(CLK_P/2) clk = ~clk;

  usb_tok_tx u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .start(start),
    .pkt_type(pkt_type), .dev_addr(dev_addr), .endp_num(endp_num),
    .busy(busy), .done(done), .line_dp(line_dp), .line_dm(line_dm)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference model built from R3..R8: J=2'b10, K=2'b01, SE0=2'b00
  task automatic build_expected(input logic [3:0] t, input logic [6:0] a, input logic [3:0] e);
    logic [31:0] raw;
    logic [4:0]  r;
    logic [10:0] cin;
    logic        lvl;
    int          ones;
    cin = {e, a};
    r = 5'b11111;
    for (int i = 0; i < 11; i++) begin
      logic fb;
      fb = cin[i] ^ r[4];
      r = {r[3:0], 1'b0} ^ (fb ? 5'b00101 : 5'b00000);
    end
    r = ~r;
    raw[7:0]   = 8'b1000_0000;
    raw[11:8]  = t;
    raw[15:12] = ~t;
    raw[22:16] = a;
    raw[26:23] = e;
    for (int j = 0; j < 5; j++) raw[27+j] = r[4-j];
    exp_n = 0;
    lvl = 1'b1;
    ones = 0;
    for (int i = 0; i < 32; i++) begin
      if (!raw[i]) lvl = ~lvl;
      ones = raw[i] ? ones + 1 : 0;
      exp_line[exp_n] = {lvl, ~lvl};
      exp_n++;
      if (ones == 6) begin
        lvl = ~lvl;
        ones = 0;
        exp_line[exp_n] = {lvl, ~lvl};
        exp_n++;
      end
    end
    exp_line[exp_n] = 2'b00; exp_n++;
    exp_line[exp_n] = 2'b00; exp_n++;
    exp_line[exp_n] = 2'b10; exp_n++;
  endtask

  task automatic run_pkt(input logic [3:0] t, input logic [6:0] a, input logic [3:0] e,
                         input int gap, input bit poke, input string body_req);
    int n;
    int bad_sync, bad_body, bad_eop, bad_hold;
    logic saw_done;
    build_expected(t, a, e);
    @(negedge clk);
    pkt_type = t; dev_addr = a; endp_num = e; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", busy, 1'b1);
    n = 0; saw_done = 1'b0; bad_hold = 0;
    while (!saw_done && n < 64) begin
      bit_en = 1'b1;
      if (poke && n == 10) begin
        start = 1'b1; pkt_type = ~t; dev_addr = ~a; endp_num = ~e;
      end
      @(negedge clk);
      bit_en = 1'b0; start = 1'b0;
      got_line[n] = {line_dp, line_dm};
      saw_done = done;
      n++;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if ({line_dp, line_dm} !== got_line[n-1]) bad_hold++;
      end
    end
    bad_sync = 0; bad_body = 0; bad_eop = 0;
    for (int i = 0; i < 8; i++) if (got_line[i] !== exp_line[i]) bad_sync++;
    for (int i = 8; i < exp_n - 3 && i < n; i++) if (got_line[i] !== exp_line[i]) bad_body++;
    for (int i = 1; i <= 3; i++)
      if (n - i < 0 || got_line[n-i] !== exp_line[exp_n-i]) bad_eop++;
    check("R3 sync symbols", bad_sync, 0);
    check(body_req, bad_body, 0);
    check("R7 stuffed length", n, exp_n);
    check("R8 end marker", bad_eop, 0);
    check("R8 done with final J", saw_done, 1'b1);
    if (gap > 0) check("R9 hold without bit_en", bad_hold, 0);
    @(negedge clk);
    check("R2 busy low after done", busy, 1'b0);
    if (poke) begin
      repeat (6) @(negedge clk);
      check("R10 no second packet", {busy, line_dp, line_dm}, 3'b010);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", {busy, done, line_dp, line_dm}, 4'b0010);
    run_pkt(4'hD, 7'h00, 4'h0, 0, 1'b0, "R4 R5 fields zero address");
    run_pkt(4'h9, 7'h55, 4'hA, 2, 1'b0, "R6 R5 alternating fields");
    run_pkt(4'h1, 7'h7F, 4'hF, 1, 1'b0, "R7 R5 all-ones fields");
    run_pkt(4'hF, 7'h3C, 4'h7, 0, 1'b0, "R4 R6 type all ones");
    run_pkt(4'h5, 7'h12, 4'h3, 3, 1'b1, "R10 R5 start during packet");
    run_pkt(4'h6, 7'h01, 4'h8, 0, 1'b0, "R5 back to back");
    @(negedge clk);
    check("R1 idle at end", {busy, done, line_dp, line_dm}, 4'b0010);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule